// File: doc/BRIEF.md
# Dual-Compare Timer Channel Match Unit

This block is the match-detection core of a single timer channel. It holds two independent compare values (side A and side B). Each clock it compares them against a free-running 24-bit time base that a neighbouring counter supplies. When a side recognizes a match, it does three things on the same edge: it stores the time-base value in that side's capture register, it sets that side's match latch, and it emits a one-cycle event pulse. The pin-action logic uses the latches and pulses, and the channel sequencer uses the captured values.

Each side has a latch-enable bit that arms recognition. A match clears the latch-enable so that a greater-or-equal compare, which stays true, cannot overwrite the first capture. Rewriting a compare value re-arms its side. The write takes precedence over every clear in the same cycle. When a match on the old value coincides with a rewrite, the outcome is fixed and depends on an option that clears the latch on write. A global enable from the sequencer gates recognition. A blocking mode couples the sides, so that a match on one side disarms the other.

Top module: `tmr_match_unit`

## Requirements
- R1: Each side compares in equal-only mode (`ge_mode`=0, true only when time base equals the compare value) or in greater-or-equal mode (`ge_mode`=1, true when (time base − compare value) mod 2^24 is below 2^23).
- R2: A side recognizes a match when `match_en` is 1, its latch-enable is 1, its latch is 0 and its compare is true. On that edge the capture register loads the time base, the latch sets, and the event output is 1 for that one cycle.
- R3: The edge on which a side recognizes a match also clears that side's latch-enable, unless that side is written in the same cycle. No further capture occurs while the compare stays true.
- R4: With `blk_mode`=1, a match recognized on one side clears the other side's latch-enable on the same edge, unless the other side is written in that cycle.
- R5: `neg_mrle`=1 clears both latch-enables. `clr_mrl_a`/`clr_mrl_b` clear one latch, but a match recognized on the same edge wins and the latch sets.
- R6: A write (`wr_a`/`wr_b`) loads the compare value and sets that side's latch-enable, overriding any clear in the same cycle. A write to one side combined with `neg_mrle` leaves that side armed and the other side disarmed.
- R7: When a side's latch is already 1 and its latch-enable is 1 with the compare true and `match_en`=1, the next edge clears the latch-enable. The capture register, the latch and the event output do not change.
- R8: A write with `clr_on_wr`=0, in a cycle where the old value matches, still sets the latch and captures the time base. Latch-enable ends at 1.
- R9: A write with `clr_on_wr`=1 clears that side's latch. A match on the old value in the same cycle still captures and pulses the event, but the latch stays 0 and latch-enable stays 1.
- R10: No match is recognized while `match_en`=0. In greater-or-equal mode a compare that became true meanwhile is recognized once `match_en` returns to 1. In equal-only mode it is lost.
- R11: Synchronous active-low reset clears both compare values, latches, latch-enables, capture registers and event outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbase | input | 24 | Free-running time base |
| match_en | input | 1 | Recognition enable from the sequencer |
| ge_mode | input | 1 | 1 = greater-or-equal compare, 0 = equal-only |
| blk_mode | input | 1 | 1 = a match on one side disarms the other |
| wr_a | input | 1 | Write compare value A and arm side A |
| wr_val_a | input | 24 | New compare value A |
| wr_b | input | 1 | Write compare value B and arm side B |
| wr_val_b | input | 24 | New compare value B |
| clr_on_wr | input | 1 | A write also clears the written side's latch |
| neg_mrle | input | 1 | Disarm both sides |
| clr_mrl_a | input | 1 | Clear latch A |
| clr_mrl_b | input | 1 | Clear latch B |
| mrl_a | output | 1 | Match latch A |
| mrl_b | output | 1 | Match latch B |
| mrle_a | output | 1 | Latch-enable A |
| mrle_b | output | 1 | Latch-enable B |
| cap_a | output | 24 | Time base captured at the last match on A |
| cap_b | output | 24 | Time base captured at the last match on B |
| evt_a | output | 1 | One-cycle pulse on a match recognized on A |
| evt_b | output | 1 | One-cycle pulse on a match recognized on B |

## Verification
On every cycle the assertions check the local relations between the gating inputs and the next state. These cover capture of the time base on a recognized match, disarming on a match, by the twin in blocking mode and by the command, and re-arming on a write. They also cover suppression of capture while the latch is held, the latch staying clear after a clear-on-write, the absence of events with the enable low, and the reset values. Some behaviours span several cycles or depend on specific values, and only the bench scenarios show them. These are modular comparison across the 2^24 wrap and at the half-range boundary, late recognition in greater-or-equal mode after the enable returns versus loss in equal-only mode, the two-step re-disarm after a write into the past, and the exact outcome when a rewrite coincides with a match on the old value. Those scenarios run against a cycle-accurate behavioural model.

// File: rtl/tmr_match_pkg.sv
// Shared types for the timer match unit.
// Assumes: consumers import or scope-reference this package.
package tmr_match_pkg;

    // Comparator behaviour selected by the sequencer.
    typedef enum logic {
        CMP_EQ = 1'b0,
        CMP_GE = 1'b1
    } cmp_mode_e;

    // Per-side control strobes gathered for one cycle.
    typedef struct packed {
        logic wr;         // load compare value and arm
        logic clr_on_wr;  // clear latch together with a write
        logic clr_mrl;    // clear latch by command
    } side_ctl_t;

endpackage

// File: rtl/tmr_match_cmp.sv
// Time-base comparator for one side.
// Equal-only mode tests for identity. Greater-or-equal mode is wrap-aware:
// the time base counts as reached when the modular distance past the compare
// value falls in the lower half of the range.
// Assumes: the time base is free-running modulo 2^TB_W.
module tmr_match_cmp #(
    parameter int TB_W = 24
) (
    input  logic [TB_W-1:0]           tb_i,
    input  logic [TB_W-1:0]           ref_i,
    input  tmr_match_pkg::cmp_mode_e  mode_i,
    output logic                      cond_o
);
    logic [TB_W-1:0] dist_w;
    logic            eq_w;
    logic            reached_w;

    // Modular distance of the time base past the compare value.
    assign dist_w    = tb_i - ref_i;
    assign eq_w      = (tb_i == ref_i);
    assign reached_w = ~dist_w[TB_W-1];

    // Select the compare result for the active mode.
    always_comb begin
        if (mode_i == tmr_match_pkg::CMP_GE) cond_o = reached_w;
        else                                  cond_o = eq_w;
    end

    // An equal time base must always satisfy greater-or-equal.
    always_comb begin
        p_ge_covers_eq_r1: assert (!(eq_w && !reached_w))
            else $error("R1: equal time base not seen as reached");
    end
endmodule

// File: rtl/tmr_match_side.sv
// One side of the dual match unit: compare register, match latch,
// latch-enable, capture register and event pulse.
// Assumes: the twin side's recognition pulse arrives combinationally,
// and a write to this side overrides every disarming source in that cycle.
module tmr_match_side #(
    parameter int TB_W = 24
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [TB_W-1:0]              tb_i,
    input  logic                         mef_i,
    input  tmr_match_pkg::cmp_mode_e     mode_i,
    input  logic                         blk_i,
    input  logic                         twin_hit_i,
    input  logic                         neg_i,
    input  tmr_match_pkg::side_ctl_t     ctl_i,
    input  logic [TB_W-1:0]              wr_val_i,
    output logic                         hit_o,
    output logic                         mrl_o,
    output logic                         mrle_o,
    output logic                         evt_o,
    output logic [TB_W-1:0]              cap_o
);
    logic [TB_W-1:0] match_q;
    logic [TB_W-1:0] cap_q;
    logic            mrl_q;
    logic            mrle_q;
    logic            evt_q;
    logic            cond_w;
    logic            hit_w;
    logic            stale_w;
    logic            drop_w;
    logic            wr_clr_w;

    tmr_match_cmp #(.TB_W(TB_W)) u_cmp (
        .tb_i   (tb_i),
        .ref_i  (match_q),
        .mode_i (mode_i),
        .cond_o (cond_w)
    );

    // Recognition needs the enable, an armed side and a free latch.
    assign hit_w    = mef_i & mrle_q & ~mrl_q & cond_w;
    // Compare true on an armed side whose latch is already held.
    assign stale_w  = mef_i & mrle_q & mrl_q & cond_w;
    // Every source that disarms this side.
    assign drop_w   = hit_w | stale_w | neg_i | (blk_i & twin_hit_i);
    assign wr_clr_w = ctl_i.wr & ctl_i.clr_on_wr;

    // Compare value register, loaded by a write.
    always_ff @(posedge clk) begin
        if (!rst_n)         match_q <= '0;
        else if (ctl_i.wr)  match_q <= wr_val_i;
    end

    // Capture register and event pulse, updated on recognition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
            evt_q <= 1'b0;
        end else begin
            evt_q <= hit_w;
            if (hit_w) cap_q <= tb_i;
        end
    end

    // Match latch: clear-on-write first, then recognition, then command clear.
    always_ff @(posedge clk) begin
        if (!rst_n)              mrl_q <= 1'b0;
        else if (wr_clr_w)       mrl_q <= 1'b0;
        else if (hit_w)          mrl_q <= 1'b1;
        else if (ctl_i.clr_mrl)  mrl_q <= 1'b0;
    end

    // Latch-enable: a write arms, any disarming source otherwise clears.
    always_ff @(posedge clk) begin
        if (!rst_n)         mrle_q <= 1'b0;
        else if (ctl_i.wr)  mrle_q <= 1'b1;
        else if (drop_w)    mrle_q <= 1'b0;
    end

    assign hit_o  = hit_w;
    assign mrl_o  = mrl_q;
    assign mrle_o = mrle_q;
    assign evt_o  = evt_q;
    assign cap_o  = cap_q;

    p_cap_on_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_w |=> (cap_q == $past(tb_i)) && evt_q)
        else $error("R2: capture or event missing after recognition");

    p_latch_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_w && !wr_clr_w |=> mrl_q)
        else $error("R2: latch not set after recognition");

    p_disarm_on_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_w && !ctl_i.wr |=> !mrle_q)
        else $error("R3: side still armed after its own match");

    p_twin_disarm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        blk_i && twin_hit_i && !ctl_i.wr |=> !mrle_q)
        else $error("R4: blocking mode left side armed");

    p_neg_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        neg_i && !ctl_i.wr |=> !mrle_q)
        else $error("R5: disarm command ignored");

    p_write_arms_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_i.wr |=> mrle_q && (match_q == $past(wr_val_i)))
        else $error("R6: write did not arm or load");

    p_held_no_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mrl_q |=> $stable(cap_q) && !evt_q)
        else $error("R7: capture while latch held");

    p_concurrent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_i.wr && !ctl_i.clr_on_wr && hit_w |=> mrl_q && mrle_q)
        else $error("R8: concurrent rewrite outcome wrong");

    p_clr_on_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr_w |=> !mrl_q && mrle_q)
        else $error("R9: clear-on-write outcome wrong");

    p_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mef_i |=> !evt_q)
        else $error("R10: event while enable low");

    p_reset_r11: assert property (@(posedge clk)
        !rst_n |=> !mrl_q && !mrle_q && !evt_q && (cap_q == '0) && (match_q == '0))
        else $error("R11: reset state wrong");
endmodule

// File: rtl/tmr_match_unit.sv
// Dual match unit of one timer channel: two compare sides sharing the time
// base, the recognition enable and the compare mode, cross-coupled for
// blocking mode.
// Assumes: the time base advances in the same clock domain, and the
// controls are single-cycle strobes from the sequencer.
module tmr_match_unit #(
    parameter int TB_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TB_W-1:0]  tbase,
    input  logic             match_en,
    input  logic             ge_mode,
    input  logic             blk_mode,
    input  logic             wr_a,
    input  logic [TB_W-1:0]  wr_val_a,
    input  logic             wr_b,
    input  logic [TB_W-1:0]  wr_val_b,
    input  logic             clr_on_wr,
    input  logic             neg_mrle,
    input  logic             clr_mrl_a,
    input  logic             clr_mrl_b,
    output logic             mrl_a,
    output logic             mrl_b,
    output logic             mrle_a,
    output logic             mrle_b,
    output logic [TB_W-1:0]  cap_a,
    output logic [TB_W-1:0]  cap_b,
    output logic             evt_a,
    output logic             evt_b
);
    import tmr_match_pkg::*;

    cmp_mode_e mode_w;
    side_ctl_t ctl_a_w;
    side_ctl_t ctl_b_w;
    logic      hit_a_w;
    logic      hit_b_w;

    // Map the mode pin onto the compare type.
    assign mode_w = ge_mode ? CMP_GE : CMP_EQ;

    // Bundle the per-side strobes.
    assign ctl_a_w = '{wr: wr_a, clr_on_wr: clr_on_wr, clr_mrl: clr_mrl_a};
    assign ctl_b_w = '{wr: wr_b, clr_on_wr: clr_on_wr, clr_mrl: clr_mrl_b};

    tmr_match_side #(.TB_W(TB_W)) u_side_a (
        .clk        (clk),
        .rst_n      (rst_n),
        .tb_i       (tbase),
        .mef_i      (match_en),
        .mode_i     (mode_w),
        .blk_i      (blk_mode),
        .twin_hit_i (hit_b_w),
        .neg_i      (neg_mrle),
        .ctl_i      (ctl_a_w),
        .wr_val_i   (wr_val_a),
        .hit_o      (hit_a_w),
        .mrl_o      (mrl_a),
        .mrle_o     (mrle_a),
        .evt_o      (evt_a),
        .cap_o      (cap_a)
    );

    tmr_match_side #(.TB_W(TB_W)) u_side_b (
        .clk        (clk),
        .rst_n      (rst_n),
        .tb_i       (tbase),
        .mef_i      (match_en),
        .mode_i     (mode_w),
        .blk_i      (blk_mode),
        .twin_hit_i (hit_a_w),
        .neg_i      (neg_mrle),
        .ctl_i      (ctl_b_w),
        .wr_val_i   (wr_val_b),
        .hit_o      (hit_b_w),
        .mrl_o      (mrl_b),
        .mrle_o     (mrle_b),
        .evt_o      (evt_b),
        .cap_o      (cap_b)
    );

    p_blk_cross_r4: assert property (@(posedge clk) disable iff (!rst_n)
        blk_mode && $rose(mrl_a) && !$past(wr_b) && !$past(clr_on_wr) |-> !mrle_b)
        else $error("R4: side B armed after match on A in blocking mode");
endmodule

// File: tb/test_tmr_match_unit.sv
module test_tmr_match_unit;
    localparam int W = 24;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] tbv;
    logic         mef, ge, blk, cow, neg;
    logic         wr [2];
    logic         cm [2];
    logic [W-1:0] wv [2];
    logic         mrl_a, mrl_b, mrle_a, mrle_b, evt_a, evt_b;
    logic [W-1:0] cap_a, cap_b;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    tmr_match_unit #(.TB_W(W)) i_tmr_match_unit (
        .clk(clk), .rst_n(rst_n), .tbase(tbv), .match_en(mef),
        .ge_mode(ge), .blk_mode(blk),
        .wr_a(wr[0]), .wr_val_a(wv[0]), .wr_b(wr[1]), .wr_val_b(wv[1]),
        .clr_on_wr(cow), .neg_mrle(neg),
        .clr_mrl_a(cm[0]), .clr_mrl_b(cm[1]),
        .mrl_a(mrl_a), .mrl_b(mrl_b), .mrle_a(mrle_a), .mrle_b(mrle_b),
        .cap_a(cap_a), .cap_b(cap_b), .evt_a(evt_a), .evt_b(evt_b)
    );

    // Behavioural reference model, one state slot per side.
    logic [W-1:0] m_val [2];
    logic [W-1:0] m_cap [2];
    bit           m_l [2];
    bit           m_e [2];
    bit           m_ev [2];

    always @(posedge clk) begin
        bit cond [2];
        bit h [2];
        bit st [2];
        if (!rst_n) begin
            for (int s = 0; s < 2; s++) begin
                m_val[s] = '0; m_cap[s] = '0;
                m_l[s] = 0; m_e[s] = 0; m_ev[s] = 0;
            end
        end else begin
            for (int s = 0; s < 2; s++) begin
                logic [W-1:0] d;
                d = tbv - m_val[s];
                cond[s] = ge ? (d < (1 << (W-1))) : (tbv == m_val[s]);
                h[s]  = mef && m_e[s] && !m_l[s] && cond[s];
                st[s] = mef && m_e[s] && m_l[s] && cond[s];
            end
            for (int s = 0; s < 2; s++) begin
                m_ev[s] = h[s];
                if (h[s]) m_cap[s] = tbv;
                if (wr[s] && cow) m_l[s] = 0;
                else if (h[s])    m_l[s] = 1;
                else if (cm[s])   m_l[s] = 0;
                if (wr[s]) m_e[s] = 1;
                else if (h[s] || st[s] || neg || (blk && h[1-s])) m_e[s] = 0;
                if (wr[s]) m_val[s] = wv[s];
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(mrl_a == m_l[0], "R2 mrl_a", W'(mrl_a), W'(m_l[0]));
            chk(mrl_b == m_l[1], "R2 mrl_b", W'(mrl_b), W'(m_l[1]));
            chk(mrle_a == m_e[0], "R3 mrle_a", W'(mrle_a), W'(m_e[0]));
            chk(mrle_b == m_e[1], "R3 mrle_b", W'(mrle_b), W'(m_e[1]));
            chk(cap_a == m_cap[0], "R2 cap_a", cap_a, m_cap[0]);
            chk(cap_b == m_cap[1], "R2 cap_b", cap_b, m_cap[1]);
            chk(evt_a == m_ev[0], "R10 evt_a", W'(evt_a), W'(m_ev[0]));
            chk(evt_b == m_ev[1], "R10 evt_b", W'(evt_b), W'(m_ev[1]));
        end
    end

    task automatic tick();
        @(negedge clk);
        for (int s = 0; s < 2; s++) begin
            wr[s] = 0; cm[s] = 0;
        end
        cow = 0; neg = 0;
    endtask

    task automatic put(input int s, input logic [W-1:0] v);
        wr[s] = 1; wv[s] = v;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst_n = 0; tbv = '0; mef = 1; ge = 0; blk = 0; cow = 0; neg = 0;
        for (int s = 0; s < 2; s++) begin wr[s] = 0; cm[s] = 0; wv[s] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R11: reset state
        chk(!mrl_a && !mrl_b && !mrle_a && !mrle_b, "R11 flags", {mrl_a, mrl_b, mrle_a, mrle_b}, 0);
        chk(cap_a == 0 && cap_b == 0, "R11 captures", cap_a | cap_b, 0);

        // Equal-only recognition at exactly the compare value
        tbv = 90; put(0, 100); tick();
        chk(mrle_a, "R6 write arms A", W'(mrle_a), 1);
        for (int t = 91; t < 100; t++) begin tbv = W'(t); tick(); end
        chk(!mrl_a, "R1 no early equal match", W'(mrl_a), 0);
        tbv = 100; tick();
        chk(mrl_a && evt_a && cap_a == 100, "R2 capture on equal", cap_a, 100);
        chk(!mrle_a, "R3 disarm after match", W'(mrle_a), 0);
        tbv = 101; put(1, 50); tick();
        chk(!evt_a, "R2 event is one cycle", W'(evt_a), 0);
        tbv = 102; tick();
        chk(!mrl_b, "R1 equal-only ignores past value", W'(mrl_b), 0);

        // Greater-or-equal, combined write plus disarm
        neg = 1; tick();
        ge = 1; neg = 1; cm[0] = 1; put(0, 200); tbv = 150; tick();
        chk(mrle_a && !mrle_b, "R6 write beats disarm", {mrle_a, mrle_b}, 2);
        chk(!mrl_a, "R5 latch clear command", W'(mrl_a), 0);
        tbv = 205; tick();
        chk(cap_a == 205 && mrl_a, "R1 GE passes value", cap_a, 205);
        tbv = 206; tick();
        chk(cap_a == 205 && !evt_a, "R3 no recapture", cap_a, 205);

        // Wraparound and half-range boundary
        put(1, 24'hFFFFF0); tbv = 24'hFFFFE0; tick();
        tbv = 24'hFFFFEF; tick();
        chk(!mrl_b, "R1 before wrap", W'(mrl_b), 0);
        tbv = 24'h000005; tick();
        chk(mrl_b && cap_b == 5, "R1 match across wrap", cap_b, 5);
        cm[1] = 1; put(1, 24'h000010); tbv = 24'h800011; tick();
        tick();
        chk(!mrl_b, "R1 beyond half range", W'(mrl_b), 0);
        tbv = 24'h80000F; tick();
        chk(mrl_b && cap_b == 24'h80000F, "R1 at half range edge", cap_b, 24'h80000F);

        // Blocking mode
        blk = 1; cm[0] = 1; cm[1] = 1; put(0, 300); put(1, 400); tbv = 290; tick();
        tbv = 300; tick();
        chk(mrl_a && !mrle_b, "R4 twin disarmed", W'(mrle_b), 0);
        tbv = 400; tick();
        chk(!mrl_b && cap_b == 24'h80000F, "R4 blocked side silent", cap_b, 24'h80000F);
        blk = 0;

        // Disarm command
        cm[0] = 1; cm[1] = 1; put(0, 2000); put(1, 2000); tbv = 1000; tick();
        neg = 1; tick();
        chk(!mrle_a && !mrle_b, "R5 both disarmed", {mrle_a, mrle_b}, 0);
        tbv = 2000; tick();
        chk(!mrl_a && !evt_a, "R5 no match when disarmed", W'(mrl_a), 0);

        // Write into the past while the latch is held
        put(0, 2100); tick();
        tbv = 2100; tick();
        put(0, 2050); tbv = 2101; tick();
        chk(mrle_a && mrl_a, "R6 rewrite re-arms", W'(mrle_a), 1);
        tbv = 2102; tick();
        chk(!mrle_a && cap_a == 2100 && !evt_a, "R7 re-disarm without capture", cap_a, 2100);

        // Rewrite coinciding with a match, latch kept
        cm[0] = 1; put(0, 2500); tbv = 2400; tick();
        tbv = 2500; put(0, 2600); tick();
        chk(mrl_a && mrle_a && cap_a == 2500, "R8 concurrent rewrite", cap_a, 2500);
        tbv = 2501; tick();
        chk(mrle_a, "R8 stays armed", W'(mrle_a), 1);

        // Rewrite coinciding with a match, clear-on-write
        cm[0] = 1; put(0, 2700); tbv = 2650; tick();
        tbv = 2700; put(0, 2800); cow = 1; tick();
        chk(!mrl_a && mrle_a && cap_a == 2700 && evt_a, "R9 capture with clear", cap_a, 2700);
        tbv = 2800; tick();
        put(0, 2900); cow = 1; tbv = 2801; tick();
        chk(!mrl_a, "R9 clear on write", W'(mrl_a), 0);

        // Enable gating
        put(0, 3000); tbv = 2850; tick();
        mef = 0; tbv = 3005; tick();
        chk(!mrl_a && !evt_a, "R10 gated", W'(mrl_a), 0);
        mef = 1; tbv = 3007; tick();
        chk(mrl_a && cap_a == 3007, "R10 GE late recognition", cap_a, 3007);
        ge = 0; cm[0] = 1; put(0, 3100); tbv = 3050; tick();
        mef = 0; tbv = 3100; tick();
        mef = 1; tbv = 3101; tick();
        tbv = 3102; tick();
        chk(!mrl_a && mrle_a, "R10 equal-only match lost", W'(mrl_a), 0);

        tick();
        finish_run();
    end
endmodule